// File: doc/BRIEF.md
# Serial PHY Management Frame Master

This block runs the serial management link between a MAC-side controller and an Ethernet PHY. It sends register write frames and register read frames on a shared management clock (`mdc`). The frame data goes out on one of two data pins: one for an on-board (internal) transceiver and one for a plug-in (external) transceiver. Each pin is modelled as three signals: an output enable, an output value and an input value. The pad that combines them lives outside the block.

A controller first pulses `probe_req`. The block briefly drives both data pins high, releases them, waits a fixed settling time and reads them back. A pin held up by a present transceiver selects that port, and the external port wins when both are present. After that, each `req_valid` pulse carries a direction flag, a 5-bit register number and 16 write data bits. The block builds the frame with the fixed PHY address of the selected port and reports completion with a one-cycle `done`. For reads, it also returns the captured 16-bit value on `rd_data`.

Top module: `mgmt_frame_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc`, both output enables and `probe_err` are 0 and `port_sel` is 2'b00. While `busy` is low, `mdc` stays low and neither data pin is driven.
- R2: A probe drives both pins to 1 with `mdc` low for exactly one half period. It then releases both pins for PROBE_US microseconds and samples them. The result is `port_sel` = 2'b10 (external) if the external pin reads 1, otherwise 2'b01 (internal) if the internal pin reads 1, otherwise 2'b00 with `probe_err` = 1. The probe ends with a `done` pulse, and `port_sel` changes at no other time.
- R3: Every frame opens with 20 `mdc` cycles during which the selected pin is driven to 1.
- R4: After the opening cycles, a write frame drives these bits, most significant bit first in each field:
  - start 0,1
  - opcode 0,1
  - the 5-bit PHY address (INT_PHY_ADDR for the internal port, EXT_PHY_ADDR for the external port)
  - the 5-bit register number
  - turnaround 1,0
  - the 16 data bits

  A write frame has 52 rising `mdc` edges in total.
- R5: A read frame drives start 0,1, opcode 1,0, the PHY address and the register number. It then releases the pin for 2 turnaround cycles, 16 data cycles and 3 trailing cycles, for 55 rising `mdc` edges in total.
- R6: At the end of a read, `rd_data` holds the 16 bits sampled in the data cycles, the first sampled bit in bit 15. `done` is high for exactly one cycle, and `busy` falls on the next cycle.
- R7: With `port_sel` = 2'b00, a read completes with `rd_data` = 16'hFFFF and a write has no effect. Neither produces an `mdc` edge or a driven pin.
- R8: During a frame, only the pin of the selected port is ever driven.
- R9: Each `mdc` half period lasts HALF_DIV = ceil(SYS_CLK_HZ / (2*MDC_MAX_HZ)) system clocks, so `mdc` never exceeds MDC_MAX_HZ. `mdc` changes only at half-period boundaries.
- R10: `busy` stays high from the accepted request until `done`. Any `req_valid` or `probe_req` that arrives while busy is ignored.
- R11: Read bits on the external pin are sampled in the last system clock of the `mdc` low phase, before the rising edge. Read bits on the internal pin are sampled in the last system clock of the `mdc` high phase, after the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a frame (taken only when idle) |
| req_write | input | 1 | 1 = write frame, 0 = read frame |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Data for a write frame |
| probe_req | input | 1 | Start a presence probe (wins over req_valid) |
| busy | output | 1 | Frame or probe in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read |
| port_sel | output | 2 | 00 none, 01 internal, 10 external |
| probe_err | output | 1 | Last probe found no transceiver |
| mdc | output | 1 | Management clock |
| int_md_oe | output | 1 | Internal data pin drive enable |
| int_md_o | output | 1 | Internal data pin output value |
| int_md_i | input | 1 | Internal data pin input value |
| ext_md_oe | output | 1 | External data pin drive enable |
| ext_md_o | output | 1 | External data pin output value |
| ext_md_i | input | 1 | External data pin input value |

## Verification
The assertions check, on every cycle:
- the quiet idle state;
- that at most one pin is driven outside the probe drive phase;
- that `mdc` edges fall only on half-period boundaries;
- that `port_sel` is held except at the probe sample point;
- the single-cycle `done` that ends `busy`;
- that a port-less block never toggles `mdc`.

Only the bench scenarios can show the bit content of each frame, the captured read value and the probe priority order. The same goes for the different sampling instants of the two ports. A PHY model flips its data bit right after each rising edge, so an external read returns the value from before the edge and an internal read returns the flipped value.

// File: rtl/mfm_pkg.sv
package mfm_pkg;

  typedef enum logic [1:0] {
    PORT_NONE = 2'b00,
    PORT_INT  = 2'b01,
    PORT_EXT  = 2'b10
  } port_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FRAME, S_PDRV, S_PWAIT, S_FIN
  } state_e;

  localparam int PRE_BITS   = 20;
  localparam int TA_START   = PRE_BITS + 14;
  localparam int DATA_START = PRE_BITS + 16;
  localparam int DATA_END   = DATA_START + 16;
  localparam int TAIL_BITS  = 3;

  // {drive, value} for bit position idx of a frame
  function automatic logic [1:0] frame_bit(input logic [5:0] idx, input logic wr,
                                           input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [15:0] wd);
    int i;
    i = int'(idx);
    if (i < PRE_BITS)             return 2'b11;
    else if (i < PRE_BITS + 2)    return {1'b1, i == PRE_BITS + 1};
    else if (i < PRE_BITS + 4)    return {1'b1, wr ? (i == PRE_BITS + 3) : (i == PRE_BITS + 2)};
    else if (i < PRE_BITS + 9)    return {1'b1, phy[PRE_BITS + 8 - i]};
    else if (i < TA_START)        return {1'b1, rg[TA_START - 1 - i]};
    else if (i < DATA_START)      return wr ? {1'b1, i == TA_START} : 2'b00;
    else if (i < DATA_END)        return wr ? {1'b1, wd[DATA_END - 1 - i]} : 2'b00;
    else                          return 2'b00;
  endfunction

  function automatic logic is_capture(input logic [5:0] idx, input logic wr);
    return !wr && (int'(idx) >= DATA_START) && (int'(idx) < DATA_END);
  endfunction

  function automatic logic [5:0] last_bit(input logic wr);
    return wr ? 6'(DATA_END - 1) : 6'(DATA_END + TAIL_BITS - 1);
  endfunction

endpackage

// File: rtl/mfm_mdc_timer.sv
module mfm_mdc_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_hi,
  output logic half_end
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt;

  assign half_end = run && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_hi <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      phase_hi <= 1'b0;
    end else if (half_end) begin
      cnt      <= '0;
      phase_hi <= ~phase_hi;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mfm_pin_steer.sv
module mfm_pin_steer
  import mfm_pkg::*;
(
  input  port_e sel,
  input  logic  frame_drive,
  input  logic  frame_val,
  input  logic  probe_drive,
  input  logic  int_md_i,
  input  logic  ext_md_i,
  output logic  int_md_oe,
  output logic  int_md_o,
  output logic  ext_md_oe,
  output logic  ext_md_o,
  output logic  md_in
);
  always_comb begin
    int_md_oe = 1'b0;
    int_md_o  = 1'b0;
    ext_md_oe = 1'b0;
    ext_md_o  = 1'b0;
    if (probe_drive) begin
      int_md_oe = 1'b1;
      int_md_o  = 1'b1;
      ext_md_oe = 1'b1;
      ext_md_o  = 1'b1;
    end else if (sel == PORT_INT) begin
      int_md_oe = frame_drive;
      int_md_o  = frame_drive & frame_val;
    end else if (sel == PORT_EXT) begin
      ext_md_oe = frame_drive;
      ext_md_o  = frame_drive & frame_val;
    end
  end

  assign md_in = (sel == PORT_EXT) ? ext_md_i : int_md_i;
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mfm_pkg::*;
#(
  parameter int         SYS_CLK_HZ   = 100_000_000,
  parameter int         MDC_MAX_HZ   = 2_500_000,
  parameter int         PROBE_US     = 20,
  parameter logic [4:0] INT_PHY_ADDR = 5'h03,
  parameter logic [4:0] EXT_PHY_ADDR = 5'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        probe_req,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic [1:0]  port_sel,
  output logic        probe_err,
  output logic        mdc,
  output logic        int_md_oe,
  output logic        int_md_o,
  input  logic        int_md_i,
  output logic        ext_md_oe,
  output logic        ext_md_o,
  input  logic        ext_md_i
);
  localparam int HALF_RAW  = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
  localparam int HALF_DIV  = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int PROBE_RAW = (SYS_CLK_HZ / 1000) * PROBE_US / 1000;
  localparam int PROBE_CYC = (PROBE_RAW < 1) ? 1 : PROBE_RAW;
  localparam int WC        = $clog2(PROBE_CYC + HALF_DIV + 1);

  state_e        st;
  port_e         port_q;
  logic [5:0]    idx;
  logic          op_wr;
  logic [4:0]    op_reg;
  logic [15:0]   op_wd;
  logic          err_q;
  logic [15:0]   shreg;
  logic [15:0]   rd_q;
  logic [WC-1:0] wcnt;

  // named internal events
  logic       phase_hi, half_end;
  logic       accept_probe, accept_req;
  logic       frame_drive, frame_val, probe_drive, md_in;
  logic       cap_ext_evt, cap_int_evt, bit_end_evt, frame_last_evt, prb_sample_evt;
  logic [4:0] phy_addr;
  logic [1:0] plan;

  assign accept_probe = (st == S_IDLE) && probe_req;
  assign accept_req   = (st == S_IDLE) && !probe_req && req_valid;
  assign phy_addr     = (port_q == PORT_EXT) ? EXT_PHY_ADDR : INT_PHY_ADDR;
  assign plan         = frame_bit(idx, op_wr, phy_addr, op_reg, op_wd);
  assign frame_drive  = (st == S_FRAME) && plan[1];
  assign frame_val    = (st == S_FRAME) && plan[0];
  assign probe_drive  = (st == S_PDRV);

  assign cap_ext_evt    = (st == S_FRAME) && (port_q == PORT_EXT) && is_capture(idx, op_wr)
                          && half_end && !phase_hi;
  assign cap_int_evt    = (st == S_FRAME) && (port_q == PORT_INT) && is_capture(idx, op_wr)
                          && half_end && phase_hi;
  assign bit_end_evt    = (st == S_FRAME) && half_end && phase_hi;
  assign frame_last_evt = bit_end_evt && (idx == last_bit(op_wr));
  assign prb_sample_evt = (st == S_PWAIT) && (wcnt == WC'(PROBE_CYC - 1));

  mfm_mdc_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st == S_FRAME),
    .phase_hi (phase_hi),
    .half_end (half_end)
  );

  mfm_pin_steer u_steer (
    .sel         (port_q),
    .frame_drive (frame_drive),
    .frame_val   (frame_val),
    .probe_drive (probe_drive),
    .int_md_i    (int_md_i),
    .ext_md_i    (ext_md_i),
    .int_md_oe   (int_md_oe),
    .int_md_o    (int_md_o),
    .ext_md_oe   (ext_md_oe),
    .ext_md_o    (ext_md_o),
    .md_in       (md_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      port_q <= PORT_NONE;
      idx    <= '0;
      op_wr  <= 1'b0;
      op_reg <= '0;
      op_wd  <= '0;
      err_q  <= 1'b0;
      shreg  <= '0;
      rd_q   <= '0;
      wcnt   <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (accept_probe) begin
            st   <= S_PDRV;
            wcnt <= '0;
          end else if (accept_req) begin
            op_wr  <= req_write;
            op_reg <= req_reg;
            op_wd  <= req_wdata;
            idx    <= '0;
            if (port_q == PORT_NONE) begin
              st <= S_FIN;
              if (!req_write) rd_q <= 16'hFFFF;
            end else begin
              st <= S_FRAME;
            end
          end
        end
        S_FRAME: begin
          if (cap_ext_evt || cap_int_evt) shreg <= {shreg[14:0], md_in};
          if (frame_last_evt) begin
            st <= S_FIN;
            if (!op_wr) rd_q <= shreg;
          end else if (bit_end_evt) begin
            idx <= idx + 1'b1;
          end
        end
        S_PDRV: begin
          if (wcnt == WC'(HALF_DIV - 1)) begin
            st   <= S_PWAIT;
            wcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_PWAIT: begin
          if (prb_sample_evt) begin
            st    <= S_FIN;
            err_q <= !ext_md_i && !int_md_i;
            if (ext_md_i)      port_q <= PORT_EXT;
            else if (int_md_i) port_q <= PORT_INT;
            else               port_q <= PORT_NONE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign rd_data   = rd_q;
  assign port_sel  = port_q;
  assign probe_err = err_q;
  assign mdc       = phase_hi;
endmodule

// File: rtl/mfm_checker.sv
module mfm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       mdc,
  input logic       int_md_oe,
  input logic       ext_md_oe,
  input logic [1:0] port_sel,
  input logic       probe_drive,
  input logic       half_end,
  input logic       prb_sample_evt
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !int_md_oe && !ext_md_oe));

  p_port_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prb_sample_evt |=> $stable(port_sel));

  p_probe_no_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_drive |-> !mdc);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_none_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel == 2'b00) |-> !mdc);

  p_one_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_drive |-> !(int_md_oe && ext_md_oe));

  p_mdc_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mdc) || $fell(mdc)) |-> $past(half_end));
endmodule

bind mgmt_frame_master mfm_checker u_mfm_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .done           (done),
  .mdc            (mdc),
  .int_md_oe      (int_md_oe),
  .ext_md_oe      (ext_md_oe),
  .port_sel       (port_sel),
  .probe_drive    (probe_drive),
  .half_end       (half_end),
  .prb_sample_evt (prb_sample_evt)
);

// File: tb/test_mgmt_frame_master.sv
module test_mgmt_frame_master;
  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 4;        // 20 MHz / (2*2.5 MHz)
  localparam logic [4:0] IADDR      = 5'h03;
  localparam logic [4:0] EADDR      = 5'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, probe_req = 1'b0;
  logic [4:0] req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, probe_err, mdc;
  logic [15:0] rd_data;
  logic [1:0] port_sel;
  logic int_md_oe, int_md_o, ext_md_oe, ext_md_o;
  logic int_md_i, ext_md_i;

  int n_chk = 0, n_err = 0;

  // PHY model state
  logic int_present = 1'b0, ext_present = 1'b0;
  logic phy_bit = 1'b1, skew = 1'b0, log_ext = 1'b0;
  logic [15:0] phy_val = '0;
  int rise_k = 0;
  logic [63:0] log_drv, log_val, log_oth;
  time t_last = 0, per_min = 0, per_max = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign int_md_i = int_md_oe ? int_md_o : (int_present ? phy_bit : 1'b0);
  assign ext_md_i = ext_md_oe ? ext_md_o : (ext_present ? phy_bit : 1'b0);

  mgmt_frame_master #(.SYS_CLK_HZ(20_000_000), .MDC_MAX_HZ(2_500_000), .PROBE_US(20),
                      .INT_PHY_ADDR(IADDR), .EXT_PHY_ADDR(EADDR)) i_mgmt_frame_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_reg(req_reg), .req_wdata(req_wdata), .probe_req(probe_req),
    .busy(busy), .done(done), .rd_data(rd_data), .port_sel(port_sel),
    .probe_err(probe_err), .mdc(mdc),
    .int_md_oe(int_md_oe), .int_md_o(int_md_o), .int_md_i(int_md_i),
    .ext_md_oe(ext_md_oe), .ext_md_o(ext_md_o), .ext_md_i(ext_md_i));

  always @(posedge mdc) begin
    if (rise_k < 64) begin
      log_drv[rise_k] = log_ext ? ext_md_oe : int_md_oe;
      log_val[rise_k] = log_ext ? ext_md_o  : int_md_o;
      log_oth[rise_k] = log_ext ? int_md_oe : ext_md_oe;
    end
    if (rise_k > 0) begin
      if ($time - t_last < per_min) per_min = $time - t_last;
      if ($time - t_last > per_max) per_max = $time - t_last;
    end
    t_last = $time;
    if (skew && rise_k >= 36 && rise_k < 52) phy_bit = ~phy_bit;
    rise_k = rise_k + 1;
  end

  always @(negedge mdc) begin
    phy_bit = (rise_k >= 36 && rise_k < 52) ? phy_val[51 - rise_k] : 1'b1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    rise_k = 0; phy_bit = 1'b1;
    log_drv = '0; log_val = '0; log_oth = '0;
    per_min = 1000000; per_max = 0;
  endtask

  task automatic do_probe(input logic ip, input logic ep);
    int both_cyc = 0, mdc_hi = 0, lim = 0;
    int_present = ip; ext_present = ep; clear_log();
    @(negedge clk); probe_req = 1'b1;
    @(negedge clk); probe_req = 1'b0;
    while (!done && lim < 3000) begin
      if (int_md_oe && ext_md_oe && int_md_o && ext_md_o) both_cyc++;
      if (mdc) mdc_hi++;
      @(negedge clk); lim++;
    end
    chk("R2 probe done seen", {31'b0, done}, 32'd1);
    chk("R2 probe drive phase length", both_cyc, HALF);
    chk("R2 probe keeps mdc low", mdc_hi, 0);
    chk("R2 probe port result", {30'b0, port_sel}, ep ? 32'd2 : (ip ? 32'd1 : 32'd0));
    chk("R2 probe error flag", {31'b0, probe_err}, {31'b0, !ip && !ep});
    @(negedge clk);
  endtask

  task automatic do_none(input logic wr);
    int oe_seen = 0, lim = 0;
    clear_log();
    @(negedge clk); req_valid = 1'b1; req_write = wr; req_reg = 5'h07; req_wdata = 16'h5A5A;
    @(negedge clk); req_valid = 1'b0;
    while (!done && lim < 100) begin
      if (int_md_oe || ext_md_oe) oe_seen++;
      @(negedge clk); lim++;
    end
    chk("R7 no-port done", {31'b0, done}, 32'd1);
    if (!wr) chk("R7 no-port read value", {16'b0, rd_data}, 32'h0000FFFF);
    chk("R7 no-port mdc edges", rise_k, 0);
    chk("R7 no-port pins released", oe_seen, 0);
    @(negedge clk);
  endtask

  task automatic do_frame(input logic wr, input logic [4:0] rg, input logic [15:0] wd,
                          input logic ext_sel, input logic sk, input logic inject);
    logic [51:0] hdr;
    int lim = 0, idle_gap = 0, dones = 0, bad_pre = 0, bad_body = 0, bad_oth = 0, k0;
    logic [15:0] exp_rd;
    hdr = {20'hFFFFF, 2'b01, (wr ? 2'b01 : 2'b10), (ext_sel ? EADDR : IADDR), rg,
           (wr ? 2'b10 : 2'b00), (wr ? wd : 16'h0000)};
    clear_log(); log_ext = ext_sel; skew = sk; phy_val = wd;
    @(negedge clk); req_valid = 1'b1; req_write = wr; req_reg = rg; req_wdata = wd;
    @(negedge clk); req_valid = 1'b0;
    while (!done && lim < 3000) begin
      if (!busy) idle_gap++;
      if (inject && lim == 50) begin req_valid = 1'b1; req_write = 1'b1; probe_req = 1'b1; end
      else begin req_valid = 1'b0; probe_req = 1'b0; end
      @(negedge clk); lim++;
    end
    req_valid = 1'b0; probe_req = 1'b0;
    if (done) dones++;
    for (int i = 0; i < 55; i++) begin
      logic ed;
      ed = (i < 52) && (wr || i < 34);
      if (log_oth[i]) bad_oth++;
      if (i < 20) begin
        if (!log_drv[i] || !log_val[i]) bad_pre++;
      end else if (log_drv[i] !== ed || (ed && log_val[i] !== hdr[51 - i])) begin
        bad_body++;
      end
    end
    exp_rd = (sk && !ext_sel) ? ~wd : wd;
    chk("R3 preamble bits", bad_pre, 0);
    if (wr) begin
      chk("R4 write frame bits", bad_body, 0);
      chk("R4 write clock count", rise_k, 52);
    end else begin
      chk("R5 read frame bits and release", bad_body, 0);
      chk("R5 read clock count", rise_k, 55);
      if (sk) chk(ext_sel ? "R11 external sample before rise" : "R11 internal sample after rise",
                  {16'b0, rd_data}, {16'b0, exp_rd});
      else chk("R6 read data", {16'b0, rd_data}, {16'b0, exp_rd});
    end
    chk("R8 other pin released", bad_oth, 0);
    chk("R9 mdc period min", int'(per_min), 2 * HALF * CLK_PERIOD);
    chk("R9 mdc period max", int'(per_max), 2 * HALF * CLK_PERIOD);
    chk("R10 busy held through frame", idle_gap, 0);
    @(negedge clk);
    chk("R6 busy low after done", {31'b0, busy}, 32'd0);
    if (inject) begin
      k0 = rise_k;
      for (int j = 0; j < 40; j++) begin
        if (done) dones++;
        if (busy) idle_gap++;
        @(negedge clk);
      end
      chk("R10 request during busy ignored", idle_gap + (rise_k - k0), 0);
      chk("R10 single completion", dones, 1);
      chk("R10 port unchanged", {30'b0, port_sel}, ext_sel ? 32'd2 : 32'd1);
    end
  endtask

  // stimulus table: {int_present, ext_present, write, reg[4:0], data[15:0]}
  localparam logic [23:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b1, 5'h00, 16'h1234},
    {1'b1, 1'b1, 1'b0, 5'h01, 16'h796D},
    {1'b1, 1'b0, 1'b1, 5'h1F, 16'hA5C3},
    {1'b1, 1'b0, 1'b0, 5'h02, 16'h8001},
    {1'b0, 1'b1, 1'b0, 5'h11, 16'hFFFE},
    {1'b0, 1'b1, 1'b1, 5'h0A, 16'h0000}
  };

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {31'b0, busy}, 32'd0);
    chk("R1 reset done", {31'b0, done}, 32'd0);
    chk("R1 reset mdc and pins", {28'b0, mdc, int_md_oe, ext_md_oe, probe_err}, 32'd0);
    chk("R1 reset port", {30'b0, port_sel}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {29'b0, busy, mdc, int_md_oe | ext_md_oe}, 32'd0);

    do_none(1'b0);
    do_none(1'b1);
    do_probe(1'b0, 1'b0);
    do_none(1'b0);

    for (int v = 0; v < 6; v++) begin
      logic [23:0] e;
      e = VEC[v];
      do_probe(e[23], e[22]);
      do_frame(e[21], e[20:16], e[15:0], e[22], 1'b0, 1'b0);
    end

    do_probe(1'b0, 1'b1);
    do_frame(1'b0, 5'h05, 16'hC3A6, 1'b1, 1'b1, 1'b0);
    do_probe(1'b1, 1'b0);
    do_frame(1'b0, 5'h06, 16'h4B1E, 1'b0, 1'b1, 1'b0);
    do_frame(1'b0, 5'h09, 16'h0F0F, 1'b0, 1'b0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule